// File: doc/BRIEF.md
# Multi-Mode Down Counter with Capture and PWM

This block is a 16-bit down counter. A 3-bit mode field sets what the counter counts, what makes it reload or capture, and what raises its two interrupt requests. In the two pulse-width modes the counter reloads from two holding registers in turn. This produces a waveform with separate high and low times, and one of the two modes drives it onto an output pin. In the two event modes the counter steps down once per edge on input pin A. In the four capture modes the counter runs on the instruction-cycle enable, and edges on pins A and B copy its value into the two holding registers.

Software reaches the mode field, the counter, both holding registers and the interrupt flags through a simple write port and a registered read port. Both pins pass through a two-stage synchroniser. Their edges are then sampled on instruction-cycle enable pulses, so each edge is seen once.

Top module: `cyc_timer`

## Requirements
- R1: After reset the counter, both holding registers, the mode field, both interrupt flags and `pin_a_out` are all 0.
- R2: In capture and PWM modes the counter steps down by one on each clock where `ce` and `run` are both high. It holds while `run` is low or `ce` is low.
- R3: Outside the PWM modes, a step taken at count 0x0000 produces 0xFFFF (underflow) and sets interrupt flag A.
- R4: In PWM modes (mode[2:1] = 10), a step taken at count 0 reloads the counter. Reloads alternate between the two holding registers, starting with the register at address 2 (A), and then the register at address 3 (B). A reload from A sets flag A and a reload from B sets flag B.
- R5: In mode 101, `pin_a_out` toggles on every PWM reload. In every other mode it holds its value.
- R6: In mode 001 the counter steps down on each rising edge of pin A, and in mode 000 on each falling edge. In both cases `run` must be high, and edges of the other polarity do nothing.
- R7: In modes 000 and 001 a rising edge on pin B sets flag B and a falling edge on pin B does not.
- R8: In mode 010, a rising edge on pin A copies the counter into register A and sets flag A. A rising edge on pin B copies the counter into register B and sets flag B. This happens whether `run` is high or low.
- R9: Mode 110 captures on a rising edge of A and a falling edge of B. Modes 011 and 111 capture on falling edges of both pins. Edges of the opposite polarity neither capture nor set a flag.
- R10: Interrupt flags are sticky and drive `irq_a`/`irq_b`. Writing address 4 clears flag A where data bit 0 is 1 and flag B where data bit 1 is 1. A set in the same cycle wins over a clear.
- R11: A write to the mode field (address 0) while `run` is high resets the PWM alternation, so that the next reload uses register A.
- R12: With `ce` high, a pin change driven before clock edge k takes effect at edge k+2 and is visible after that edge.
- R13: Address map: 0 mode (bits 2:0), 1 counter, 2 register A, 3 register B, 4 flags (bit 0 A, bit 1 B). `rd_data` shows the register selected by `rd_addr` one clock edge later. A counter write overrides a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Instruction-cycle clock enable |
| run | input | 1 | Counter run enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Registered read data |
| pin_a_in | input | 1 | Input pin A |
| pin_b_in | input | 1 | Input pin B |
| pin_a_out | output | 1 | Output pin A |
| irq_a | output | 1 | Interrupt request A (sticky flag) |
| irq_b | output | 1 | Interrupt request B (sticky flag) |

## Verification
Counter steps, reloads, captures of software-written values and flag changes all appear after the clock edge on which their cause is present. Register writes take effect on the edge of the write, and read data follows one edge after the address. Pin edges pass through two sync stages and one sampling stage, so their effects land on the third edge after the pin is driven. The bench checks irq B at edges two and three to pin that down, and it waits four edges before reading captured values. All inputs change and all outputs are sampled on the falling clock edge, so every expected value is tied to a counted number of rising edges.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_HOLDA = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_HOLDB = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_FLAGS = 3'd4;

  localparam logic [2:0] M_EVT_FALL  = 3'b000;
  localparam logic [2:0] M_EVT_RISE  = 3'b001;
  localparam logic [2:0] M_CAP_RR    = 3'b010;
  localparam logic [2:0] M_CAP_FF    = 3'b011;
  localparam logic [2:0] M_PWM_QUIET = 3'b100;
  localparam logic [2:0] M_PWM_TOG   = 3'b101;
  localparam logic [2:0] M_CAP_RF    = 3'b110;
  localparam logic [2:0] M_CAP_FF2   = 3'b111;

  function automatic logic is_pwm(input logic [2:0] m);
    return m[2:1] == 2'b10;
  endfunction

  function automatic logic is_evt(input logic [2:0] m);
    return m[2:1] == 2'b00;
  endfunction

  function automatic logic is_cap(input logic [2:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/cyc_timer_edge.sv
module cyc_timer_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              synced;

  assign synced = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      if (ce) last_q <= synced;
    end
  end

  // Edges are judged only on enable cycles, so one edge gives one pulse.
  assign rise = ce & synced & ~last_q;
  assign fall = ce & ~synced & last_q;
endmodule

// File: rtl/cyc_timer_count.sv
module cyc_timer_count
  import cyc_timer_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic         run,
  input  logic [2:0]   mode,
  input  logic         a_rise,
  input  logic         a_fall,
  input  logic         cnt_wr,
  input  logic         mode_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hold_a,
  input  logic [W-1:0] hold_b,
  output logic [W-1:0] count_q,
  output logic         phase_q,
  output logic         tick,
  output logic         ev_uf,
  output logic         ev_ld_a,
  output logic         ev_ld_b,
  output logic         pin_out_q
);
  localparam logic [W-1:0] ONE = W'(1);

  logic pwm, evt, evt_edge, uf;

  assign pwm      = is_pwm(mode);
  assign evt      = is_evt(mode);
  assign evt_edge = mode[0] ? a_rise : a_fall;
  assign tick     = run & (evt ? evt_edge : ce);
  assign uf       = tick & (count_q == '0) & ~cnt_wr;

  assign ev_uf   = uf & ~pwm;
  assign ev_ld_a = uf & pwm & ~phase_q;
  assign ev_ld_b = uf & pwm & phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= '0;
      phase_q   <= 1'b0;
      pin_out_q <= 1'b0;
    end else begin
      if (cnt_wr) begin
        count_q <= wdata;
      end else if (tick) begin
        if (uf && pwm) count_q <= phase_q ? hold_b : hold_a;
        else           count_q <= count_q - ONE;
      end

      if (mode_wr && run)  phase_q <= 1'b0;
      else if (uf && pwm)  phase_q <= ~phase_q;

      if (uf && mode == M_PWM_TOG) pin_out_q <= ~pin_out_q;
    end
  end
endmodule

// File: rtl/cyc_timer_regs.sv
module cyc_timer_regs
  import cyc_timer_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic [W-1:0]  count,
  input  logic          a_rise,
  input  logic          a_fall,
  input  logic          b_rise,
  input  logic          b_fall,
  input  logic          ev_uf,
  input  logic          ev_ld_a,
  input  logic          ev_ld_b,
  output logic [2:0]    mode_q,
  output logic [W-1:0]  hold_a_q,
  output logic [W-1:0]  hold_b_q,
  output logic          flag_a_q,
  output logic          flag_b_q,
  output logic [W-1:0]  rd_data_q,
  output logic          cnt_wr,
  output logic          mode_wr,
  output logic          clr_a
);
  logic wr_ha, wr_hb, wr_fl, clr_b;
  logic a_sel, b_sel, cap_a, cap_b, set_a, set_b;

  assign mode_wr = wr_en && wr_addr == ADR_MODE;
  assign cnt_wr  = wr_en && wr_addr == ADR_COUNT;
  assign wr_ha   = wr_en && wr_addr == ADR_HOLDA;
  assign wr_hb   = wr_en && wr_addr == ADR_HOLDB;
  assign wr_fl   = wr_en && wr_addr == ADR_FLAGS;
  assign clr_a   = wr_fl & wr_data[0];
  assign clr_b   = wr_fl & wr_data[1];

  // Edge polarity per capture mode.
  assign a_sel = (mode_q == M_CAP_FF || mode_q == M_CAP_FF2) ? a_fall : a_rise;
  assign b_sel = (mode_q == M_CAP_RR) ? b_rise : b_fall;
  assign cap_a = is_cap(mode_q) & a_sel;
  assign cap_b = is_cap(mode_q) & b_sel;

  assign set_a = cap_a | ev_uf | ev_ld_a;
  assign set_b = cap_b | (is_evt(mode_q) & b_rise) | ev_ld_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      hold_a_q  <= '0;
      hold_b_q  <= '0;
      flag_a_q  <= 1'b0;
      flag_b_q  <= 1'b0;
      rd_data_q <= '0;
    end else begin
      if (mode_wr) mode_q <= wr_data[2:0];

      if (cap_a)      hold_a_q <= count;
      else if (wr_ha) hold_a_q <= wr_data;

      if (cap_b)      hold_b_q <= count;
      else if (wr_hb) hold_b_q <= wr_data;

      flag_a_q <= set_a | (flag_a_q & ~clr_a);
      flag_b_q <= set_b | (flag_b_q & ~clr_b);

      case (rd_addr)
        ADR_MODE:  rd_data_q <= W'(mode_q);
        ADR_COUNT: rd_data_q <= count;
        ADR_HOLDA: rd_data_q <= hold_a_q;
        ADR_HOLDB: rd_data_q <= hold_b_q;
        ADR_FLAGS: rd_data_q <= W'({flag_b_q, flag_a_q});
        default:   rd_data_q <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cyc_timer.sv
module cyc_timer
  import cyc_timer_pkg::*;
#(
  parameter int W         = CNT_W,
  parameter int AW        = ADDR_W,
  parameter int SYNC_STGS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          run,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          pin_a_in,
  input  logic          pin_b_in,
  output logic          pin_a_out,
  output logic          irq_a,
  output logic          irq_b
);
  localparam int NPINS = 2;

  logic [NPINS-1:0] pins, rise, fall;
  logic [2:0]       mode_q;
  logic [W-1:0]     count_q, hold_a_q, hold_b_q;
  logic             phase_q, tick, ev_uf, ev_ld_a, ev_ld_b;
  logic             cnt_wr, mode_wr, clr_a;

  assign pins = {pin_b_in, pin_a_in};

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    cyc_timer_edge #(.STAGES(SYNC_STGS)) u_edge (
      .clk (clk),
      .rst (rst),
      .ce  (ce),
      .pin (pins[g]),
      .rise(rise[g]),
      .fall(fall[g])
    );
  end

  cyc_timer_count #(.W(W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .run      (run),
    .mode     (mode_q),
    .a_rise   (rise[0]),
    .a_fall   (fall[0]),
    .cnt_wr   (cnt_wr),
    .mode_wr  (mode_wr),
    .wdata    (wr_data),
    .hold_a   (hold_a_q),
    .hold_b   (hold_b_q),
    .count_q  (count_q),
    .phase_q  (phase_q),
    .tick     (tick),
    .ev_uf    (ev_uf),
    .ev_ld_a  (ev_ld_a),
    .ev_ld_b  (ev_ld_b),
    .pin_out_q(pin_a_out)
  );

  cyc_timer_regs #(.W(W), .AW(AW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .count    (count_q),
    .a_rise   (rise[0]),
    .a_fall   (fall[0]),
    .b_rise   (rise[1]),
    .b_fall   (fall[1]),
    .ev_uf    (ev_uf),
    .ev_ld_a  (ev_ld_a),
    .ev_ld_b  (ev_ld_b),
    .mode_q   (mode_q),
    .hold_a_q (hold_a_q),
    .hold_b_q (hold_b_q),
    .flag_a_q (irq_a),
    .flag_b_q (irq_b),
    .rd_data_q(rd_data),
    .cnt_wr   (cnt_wr),
    .mode_wr  (mode_wr),
    .clr_a    (clr_a)
  );
endmodule

// File: rtl/cyc_timer_chk.sv
module cyc_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         run,
  input logic [2:0]   mode,
  input logic [W-1:0] count,
  input logic [W-1:0] hold_a,
  input logic         phase,
  input logic         tick,
  input logic         cnt_wr,
  input logic         clr_a,
  input logic         irq_a,
  input logic         pin_a_out
);
  // R2: a stopped counter holds unless software writes it
  a_r2_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(count));

  // R3: underflow outside PWM wraps to all ones
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && count == '0 && mode[2:1] != 2'b10 && !cnt_wr) |=> count == '1);

  // R4: first-phase PWM reload takes register A
  a_r4_reload_a: assert property (@(posedge clk) disable iff (rst)
    (tick && count == '0 && mode[2:1] == 2'b10 && !cnt_wr && !phase)
      |=> count == $past(hold_a));

  // R5: output pin moves only in the toggling PWM mode
  a_r5_pin_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode != 3'b101) |=> $stable(pin_a_out));

  // R10: flag A stays set until cleared
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_a && !clr_a) |=> irq_a);
endmodule

bind cyc_timer cyc_timer_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .run      (run),
  .mode     (mode_q),
  .count    (count_q),
  .hold_a   (hold_a_q),
  .phase    (phase_q),
  .tick     (tick),
  .cnt_wr   (cnt_wr),
  .clr_a    (clr_a),
  .irq_a    (irq_a),
  .pin_a_out(pin_a_out)
);

// File: tb/cyc_timer_tb.sv
module cyc_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce = 1'b1;
  logic        run = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        pin_a_in = 1'b0;
  logic        pin_b_in = 1'b0;
  logic        pin_a_out, irq_a, irq_b;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cyc_timer u_dut (
    .clk(clk), .rst(rst), .ce(ce), .run(run),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .pin_a_in(pin_a_in), .pin_b_in(pin_b_in),
    .pin_a_out(pin_a_out), .irq_a(irq_a), .irq_b(irq_b)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; run = 1'b0; ce = 1'b1; wr_en = 1'b0;
    pin_a_in = 1'b0; pin_b_in = 1'b0;
    step(2);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a;
    @(posedge clk); @(negedge clk);
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    chk("R1 irq_a", 16'(irq_a), 0);
    chk("R1 irq_b", 16'(irq_b), 0);
    chk("R1 pin_a_out", 16'(pin_a_out), 0);
    for (int i = 0; i < 5; i++) begin
      rd(3'(i), v);
      chk("R1 R13 reset register", v, 0);
    end
  endtask

  task automatic t_count();
    logic [15:0] v;
    do_reset();
    wr(3'd0, 16'h2);
    wr(3'd1, 16'd10);
    run = 1'b1; step(3); run = 1'b0;
    rd(3'd1, v); chk("R2 three steps", v, 16'd7);
    step(5);
    rd(3'd1, v); chk("R2 hold while stopped", v, 16'd7);
    run = 1'b1;
    for (int i = 0; i < 4; i++) begin
      ce = 1'b1; step(1); ce = 1'b0; step(3);
    end
    run = 1'b0; ce = 1'b1;
    rd(3'd1, v); chk("R2 ce gating", v, 16'd3);
    rd(3'd0, v); chk("R13 mode readback", v, 16'h2);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    do_reset();
    wr(3'd0, 16'h2);
    wr(3'd1, 16'd1);
    run = 1'b1; step(2); run = 1'b0;
    rd(3'd1, v); chk("R3 wrap value", v, 16'hFFFF);
    chk("R3 underflow flag", 16'(irq_a), 1);
    wr(3'd4, 16'h2);
    chk("R10 clear other bit keeps A", 16'(irq_a), 1);
    wr(3'd4, 16'h1);
    chk("R10 clear A", 16'(irq_a), 0);
  endtask

  task automatic t_pwm(input logic [2:0] m);
    logic exp_tog;
    exp_tog = (m == 3'b101);
    do_reset();
    wr(3'd2, 16'd3);
    wr(3'd3, 16'd5);
    wr(3'd0, 16'(m));
    run = 1'b1; step(1);
    chk("R5 out after first reload", 16'(pin_a_out), 16'(exp_tog));
    chk("R4 flag A on A reload", 16'(irq_a), 1);
    chk("R4 no flag B yet", 16'(irq_b), 0);
    step(3);
    chk("R4 no B reload early", 16'(irq_b), 0);
    step(1);
    chk("R4 flag B on B reload", 16'(irq_b), 1);
    chk("R5 out after B reload", 16'(pin_a_out), 0);
    step(6);
    chk("R5 out after second A reload", 16'(pin_a_out), 16'(exp_tog));
    run = 1'b0;
  endtask

  task automatic t_phase();
    logic [15:0] v;
    do_reset();
    wr(3'd2, 16'd3);
    wr(3'd3, 16'd5);
    wr(3'd0, 16'h4);
    run = 1'b1; step(1);
    wr(3'd0, 16'h4);
    step(3); run = 1'b0;
    rd(3'd1, v); chk("R11 reload uses A after mode write", v, 16'd3);
    chk("R11 no B reload", 16'(irq_b), 0);
  endtask

  task automatic t_event(input logic [2:0] m);
    logic [15:0] v;
    do_reset();
    wr(3'd0, 16'(m));
    wr(3'd1, 16'd5);
    run = 1'b1;
    pin_a_in = 1'b1; step(4);
    rd(3'd1, v); chk("R6 after rising A", v, (m == 3'b001) ? 16'd4 : 16'd5);
    pin_a_in = 1'b0; step(4);
    rd(3'd1, v); chk("R6 after falling A", v, 16'd4);
    run = 1'b0;
    pin_a_in = 1'b1; step(4); pin_a_in = 1'b0; step(4);
    rd(3'd1, v); chk("R6 no count while stopped", v, 16'd4);
  endtask

  task automatic t_evt_b();
    do_reset();
    wr(3'd0, 16'h1);
    pin_b_in = 1'b1; step(2);
    chk("R12 not yet at edge two", 16'(irq_b), 0);
    step(1);
    chk("R7 R12 flag B at edge three", 16'(irq_b), 1);
    wr(3'd4, 16'h2);
    pin_b_in = 1'b0; step(4);
    chk("R7 falling B ignored", 16'(irq_b), 0);
  endtask

  task automatic t_cap_rr();
    logic [15:0] v;
    do_reset();
    wr(3'd0, 16'h2);
    wr(3'd1, 16'd100);
    pin_a_in = 1'b1; step(4);
    chk("R8 flag A", 16'(irq_a), 1);
    rd(3'd2, v); chk("R8 capture A", v, 16'd100);
    pin_b_in = 1'b1; step(4);
    chk("R8 flag B", 16'(irq_b), 1);
    rd(3'd3, v); chk("R8 capture B", v, 16'd100);
  endtask

  task automatic t_cap_rf();
    logic [15:0] v;
    do_reset();
    wr(3'd0, 16'h6);
    wr(3'd1, 16'd50);
    pin_b_in = 1'b1; step(4);
    chk("R9 rising B ignored flag", 16'(irq_b), 0);
    rd(3'd3, v); chk("R9 rising B ignored value", v, 16'd0);
    pin_b_in = 1'b0; step(4);
    chk("R9 falling B flag", 16'(irq_b), 1);
    rd(3'd3, v); chk("R9 falling B capture", v, 16'd50);
    pin_a_in = 1'b1; step(4);
    rd(3'd2, v); chk("R9 rising A capture", v, 16'd50);
  endtask

  task automatic t_cap_ff(input logic [2:0] m);
    logic [15:0] v;
    do_reset();
    wr(3'd0, 16'(m));
    wr(3'd1, 16'd77);
    pin_a_in = 1'b1; step(4);
    chk("R9 rising A ignored flag", 16'(irq_a), 0);
    rd(3'd2, v); chk("R9 rising A ignored value", v, 16'd0);
    pin_a_in = 1'b0; step(4);
    chk("R9 falling A flag", 16'(irq_a), 1);
    rd(3'd2, v); chk("R9 falling A capture", v, 16'd77);
    pin_b_in = 1'b1; step(4); pin_b_in = 1'b0; step(4);
    rd(3'd3, v); chk("R9 falling B capture", v, 16'd77);
  endtask

  initial begin
    t_reset();
    t_count();
    t_wrap();
    t_pwm(3'b101);
    t_pwm(3'b100);
    t_phase();
    t_event(3'b001);
    t_event(3'b000);
    t_evt_b();
    t_cap_rr();
    t_cap_rf();
    t_cap_ff(3'b011);
    t_cap_ff(3'b111);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule